// File: doc/BRIEF.md
# VGA Line Doubler with Ping-Pong Line Buffers

This block takes game video that a renderer produces one line at a time (256 pixels by 240 lines by default) and shows it as a 640x480, 60 Hz VGA raster. There is no frame store. Two single-line buffers alternate between two roles. The renderer fills one buffer while the raster reads the other. The roles swap every second VGA line, so each game line is shown on two VGA lines. Each stored pixel is held for two pixel clocks, so one game pixel becomes a 2x2 block on screen. The 512-column picture sits in the middle of the 640-column active area, with 64 black columns on each side.

The renderer is paced by a one-cycle `new_line_o` pulse. After each pulse it has two VGA lines to fill the write buffer through a plain address, data and enable port. The pixel output is a palette index. A separate blanking flag tells the palette stage, which is outside this block, to force black. All positions below use the default parameters and scale with them. A raster position is written (column, line), with column 0 being the first active column.

Top module: `vga_line_doubler`

## Requirements
- R1: A line is 800 clocks long and a frame is 525 lines. `hsync_o` is low for the 96 columns 656..751 of every line and high otherwise. `vsync_o` is low throughout lines 490 and 491 and high otherwise.
- R2: While `rst_ni` is low, the outputs are `hsync_o`=1, `vsync_o`=1, `blank_o`=1, `pix_o`=0 and `new_line_o`=0. After the n-th rising clock edge following reset release (counting from n=1), the outputs show raster position n-1. Position 0 is column 0 of line 523, two lines before the first visible line.
- R3: `new_line_o` is a one-cycle pulse at column 0 of line 523 and at column 0 of each even line from 0 to 476. It is low at every other position, so a frame has exactly 240 pulses (one per game line).
- R4: Data written to address x after a pulse is shown for game line L on VGA lines 2L and 2L+1. L is 0 for the pulse on line 523 and v/2+1 for the pulse on line v.
- R5: Game pixel x is shown on exactly two consecutive columns, 64+2x and 65+2x, of lines 0..479.
- R6: On lines 0..479, columns 0..63 and 576..639 output `blank_o`=1 and `pix_o`=0.
- R7: Every position in column 640 or later, or on line 480 or later, outputs `blank_o`=1 and `pix_o`=0. Inside the picture, `blank_o` is 0.
- R8: A cycle with `wr_en_i`=0 stores nothing, whatever `wr_addr_i` and `wr_data_i` carry.
- R9: A write to the buffer being filled never alters the pixel shown in the same or any later cycle of the current display line. This holds even when the write hits the address being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Renderer write strobe |
| wr_addr_i | input | AW (8) | Renderer pixel address within the line |
| wr_data_i | input | PIX_W (8) | Renderer palette index |
| new_line_o | output | 1 | One-cycle request to render the next game line |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High where the palette stage must output black |
| pix_o | output | PIX_W (8) | Palette index of the displayed pixel, 0 when blanked |

## Verification
The renderer write and the display read can fall in the same cycle at the same address, one in each buffer. The swap of buffer roles can also coincide with the start of a new fill. The bench provokes the first case on every odd game line by timing each write so that its address equals the column pair being read at that edge. On even game lines it writes sequentially right after the pulse, and inserts cycles with the strobe low and corrupt data. A behavioural raster model predicts every output on every clock. Each game line carries a pulse-specific data signature, so a wrong buffer choice, a stale line or a corrupted pixel is caught at the pixel port.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
package sd_pkg;

  typedef struct packed {
    logic new_line;
    logic hsync_n;
    logic vsync_n;
    logic blank;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{new_line: 1'b0, hsync_n: 1'b1, vsync_n: 1'b1, blank: 1'b1};

  function automatic logic in_span(input int unsigned p, input int unsigned lo, input int unsigned hi);
    return (p >= lo) && (p < hi);
  endfunction

endpackage

// File: rtl/sd_timing.sv
`timescale 1ns/1ps
module sd_timing #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_TOTAL = 525,
  parameter int unsigned V_START = 523,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= VW'(V_START);
    end else if (h_q == HW'(H_TOTAL - 1)) begin
      h_q <= '0;
      v_q <= (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  // R1: line end wraps the column and advances the line
  a_r1_line_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q == HW'(H_TOTAL - 1)) |=> (h_q == '0) && (v_q != $past(v_q)));

  // R1: line number holds inside a line
  a_r1_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q != HW'(H_TOTAL - 1)) |=> $stable(v_q));

endmodule

// File: rtl/sd_line_bufs.sv
`timescale 1ns/1ps
module sd_line_bufs #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              show_q;  // bank being displayed; the other one is filled
  logic [DATA_W-1:0] bank_rd [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     show_q <= 1'b0;
    else if (swap_i) show_q <= ~show_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (show_q != 1'(b))) mem_q[wr_addr_i] <= wr_data_i;
    end
    assign bank_rd[b] = mem_q[rd_addr_i];
  end

  assign rd_data_o = bank_rd[show_q];

  // R9: a write never disturbs what is being read when roles hold
  a_r9_read_undisturbed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && wr_en_i) |=> ($stable(rd_addr_i) |-> $stable(rd_data_o)));

endmodule

// File: rtl/vga_line_doubler.sv
`timescale 1ns/1ps
module vga_line_doubler
  import sd_pkg::*;
#(
  parameter int unsigned GAME_W   = 256,
  parameter int unsigned GAME_H   = 240,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_FP     = 16,
  parameter int unsigned H_SYNC   = 96,
  parameter int unsigned H_BP     = 48,
  parameter int unsigned V_FP     = 10,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_BP     = 33,
  localparam int unsigned AW = $clog2(GAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [PIX_W-1:0] wr_data_i,
  output logic             new_line_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             blank_o,
  output logic [PIX_W-1:0] pix_o
);

  localparam int unsigned V_ACTIVE = 2 * GAME_H;
  localparam int unsigned H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int unsigned BORDER   = (H_ACTIVE - 2 * GAME_W) / 2;
  localparam int unsigned PIC_END  = BORDER + 2 * GAME_W;
  localparam int unsigned HS_BEG   = H_ACTIVE + H_FP;
  localparam int unsigned VS_BEG   = V_ACTIVE + V_FP;
  localparam int unsigned PRE_LINE = V_TOTAL - 2;
  localparam int unsigned HW       = $clog2(H_TOTAL);
  localparam int unsigned VW       = $clog2(V_TOTAL);

  logic [HW-1:0]    h_q;
  logic [VW-1:0]    v_q;
  logic [31:0]      h32, v32;
  logic             in_pic, line_start, even_line, swap, req;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] rd_data;
  ctl_t             ctl_d, ctl_q;
  logic [PIX_W-1:0] pix_q;

  sd_timing #(
    .H_TOTAL(H_TOTAL),
    .V_TOTAL(V_TOTAL),
    .V_START(PRE_LINE)
  ) u_timing (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .h_o   (h_q),
    .v_o   (v_q)
  );

  assign h32        = 32'(h_q);
  assign v32        = 32'(v_q);
  assign in_pic     = in_span(h32, BORDER, PIC_END) && (v32 < V_ACTIVE);
  assign line_start = (h32 == 0);
  assign even_line  = ~v_q[0];
  // roles swap at the start of each game line; fill of the freed buffer is requested there
  assign swap       = line_start && even_line && (v32 < V_ACTIVE);
  assign req        = line_start && ((even_line && (v32 + 2 < V_ACTIVE)) || (v32 == PRE_LINE));
  assign rd_addr    = AW'((h32 - BORDER) >> 1);

  sd_line_bufs #(
    .DEPTH (GAME_W),
    .DATA_W(PIX_W)
  ) u_bufs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .swap_i   (swap),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  always_comb begin
    ctl_d.new_line = req;
    ctl_d.hsync_n  = ~in_span(h32, HS_BEG, HS_BEG + H_SYNC);
    ctl_d.vsync_n  = ~in_span(v32, VS_BEG, VS_BEG + V_SYNC);
    ctl_d.blank    = ~in_pic;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_IDLE;
      pix_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      pix_q <= in_pic ? rd_data : '0;
    end
  end

  assign new_line_o = ctl_q.new_line;
  assign hsync_o    = ctl_q.hsync_n;
  assign vsync_o    = ctl_q.vsync_n;
  assign blank_o    = ctl_q.blank;
  assign pix_o      = pix_q;

  // R3: request is a single-cycle pulse
  a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_line_o |=> !new_line_o);

  // R3: no request during vertical blanking except the pre-render one
  a_r3_no_vblank_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_line_o |-> ((v32 + 2 < V_ACTIVE) || (v32 == PRE_LINE)));

  // R6, R7: blanked positions carry index zero
  a_r6_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (pix_o == '0));

  // R1: vertical sync only inside blanking
  a_r1_vsync_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> blank_o);

endmodule

// File: tb/tb_vga_line_doubler.sv
`timescale 1ns/1ps
module tb_vga_line_doubler;

  localparam int GW = 16, GH = 8;
  localparam int HA = 40, HF = 2, HS = 4, HB = 3;
  localparam int VF = 2, VS = 2, VB = 3;
  localparam int VA  = 2 * GH;
  localparam int HT  = HA + HF + HS + HB;
  localparam int VT  = VA + VF + VS + VB;
  localparam int BD  = (HA - 2 * GW) / 2;
  localparam int PRE = VT - 2;
  localparam int AW  = $clog2(GW);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          new_line, hsync, vsync, blank;
  logic [7:0]    pix;

  always #2.5 clk = ~clk;

  vga_line_doubler #(
    .GAME_W(GW), .GAME_H(GH), .PIX_W(8),
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .new_line_o(new_line), .hsync_o(hsync), .vsync_o(vsync),
    .blank_o(blank), .pix_o(pix)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] pd(input int s, input int x);
    return 8'(x * 13 + s * 29 + 1);
  endfunction

  // behavioural raster model
  int mh = 0, mv = PRE;
  bit started = 0;
  int ev_h, ev_v;
  bit e_nl, e_hs, e_vs, e_bl;
  logic [7:0] e_px;
  int salt [GH];

  always @(posedge clk) begin
    if (rst_ni) begin
      ev_h = mh;
      ev_v = mv;
      e_bl = !(mv < VA && mh >= BD && mh < BD + 2 * GW);
      e_px = e_bl ? 8'd0 : pd(salt[mv / 2], (mh - BD) / 2);
      e_hs = !(mh >= HA + HF && mh < HA + HF + HS);
      e_vs = !(mv >= VA + VF && mv < VA + VF + VS);
      e_nl = (mh == 0) && ((mv % 2 == 0 && mv < VA - 2) || mv == PRE);
      started = 1;
      mh++;
      if (mh == HT) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end
    end
  end

  // compare every cycle, then act as the renderer
  int serial = 0, tgt = -1, mode = 0, wx = 0, step = 0, off = 0;
  int pulses = 0, hs_run = 0;
  bit frame_seen = 0;

  always @(negedge clk) begin
    if (started && !done) begin
      chk(new_line == e_nl, "R3 new_line_o", int'(new_line), int'(e_nl));
      chk(hsync == e_hs, "R1 hsync_o", int'(hsync), int'(e_hs));
      chk(vsync == e_vs, "R1 vsync_o", int'(vsync), int'(e_vs));
      chk(blank == e_bl, "R6 R7 blank_o", int'(blank), int'(e_bl));
      if (e_bl) chk(pix == e_px, "R6 R7 pix_o blanked", int'(pix), int'(e_px));
      else      chk(pix == e_px, "R4 R5 R8 R9 pix_o", int'(pix), int'(e_px));

      if (ev_h == 0 && ev_v == PRE) begin
        if (frame_seen) chk(pulses == GH, "R3 pulses per frame", pulses, GH);
        pulses = 0;
        frame_seen = 1;
      end
      if (new_line) pulses++;

      if (!hsync) hs_run++;
      else begin
        if (hs_run != 0) chk(hs_run == HS, "R1 hsync width", hs_run, HS);
        hs_run = 0;
      end

      if (new_line) begin
        tgt = (ev_v == PRE) ? 0 : ev_v / 2 + 1;
        serial++;
        salt[tgt] = serial;
        mode = (tgt % 2 == 0) ? 1 : 2;
        wx = 0;
        step = 0;
      end

      wr_en   = 1'b0;
      wr_addr = AW'(step);
      wr_data = 8'h5A ^ 8'(step);
      if (mode == 1) begin
        // sequential fill with idle strobes carrying corrupt data (R8)
        if (step % 4 == 3) begin
          wr_addr = AW'(wx - 1);
          wr_data = ~pd(serial, wx - 1);
        end else begin
          wr_en   = 1'b1;
          wr_addr = AW'(wx);
          wr_data = pd(serial, wx);
          wx++;
          if (wx == GW) mode = 0;
        end
        step++;
      end else if (mode == 2) begin
        // write each address in the very cycle the display reads it (R9)
        if (mh >= BD && mh < BD + 2 * GW) begin
          off = mh - BD;
          wr_addr = AW'(off / 2);
          if (off % 2 == 0) begin
            wr_en   = 1'b1;
            wr_data = pd(serial, off / 2);
            if (off / 2 == GW - 1) mode = 0;
          end else begin
            wr_data = ~pd(serial, off / 2);
          end
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(hsync == 1'b1, "R2 reset hsync_o", int'(hsync), 1);
    chk(vsync == 1'b1, "R2 reset vsync_o", int'(vsync), 1);
    chk(blank == 1'b1, "R2 reset blank_o", int'(blank), 1);
    chk(pix == 8'd0, "R2 reset pix_o", int'(pix), 0);
    chk(new_line == 1'b0, "R2 reset new_line_o", int'(new_line), 0);
    rst_ni = 1'b1;
    repeat (3 * HT * VT + 5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule